// File: doc/BRIEF.md
# Converter Power-Up Bring-Up Sequencer

This block is the host-side controller that takes a high-speed data converter from power-up to active operation. Once the system reset is released, or when a start pulse arrives, it first waits out a power-on delay. It then drives the converter's active-low hardware reset pin low for a bounded pulse and waits a settling gap. Next it waits for a level indication that the sampling clock and analog input are present. Only then does it issue register writes.

The writes form a fixed ordered list. Each one goes to a separate serial-write engine through a request/acknowledge handshake that carries an 8-bit register address and a 16-bit data word. The list has four parts, in this order:

- It enables the gain/offset correction circuit.
- It issues an optional parameterized table of extra writes.
- It sets the accumulator-clear bit, which wipes the correction accumulators.
- It clears the same bit, which starts the automatic offset and gain correction loop.

All delays come from parameters (clock in MHz, delays in µs or ns) and are rounded so that every minimum is met.

Top module: `adc_bringup_seq`

## Requirements
- R1: After the internal reset releases or after `start_i` is sampled high, `adc_rst_no` stays high for at least PWRUP_US×CLK_MHZ clock cycles before it goes low. It goes low no more than three cycles later than that bound.
- R2: Each low pulse on `adc_rst_no` lasts exactly floor(RST_NS×CLK_MHZ/1000)+1 cycles. This is strictly longer than RST_NS.
- R3: No write request is raised before the reset pulse ends. The first request comes no earlier than ceil(GAP_NS×CLK_MHZ/1000) cycles after `adc_rst_no` rises.
- R4: While `analog_ready_i` is low after the gap, no write request is raised and no write is issued.
- R5: The writes follow this order:
  - address 0x01 with data CORR_BASE with bit 15 set;
  - then extra entry k (address EXTRA_ADDR[8k+7:8k], data EXTRA_DATA[16k+15:16k]) for k = 0 up to N_EXTRA−1;
  - then address 0x03 with ACC_BASE with bit 14 set;
  - then address 0x03 with ACC_BASE with bit 14 cleared.
- R6: `wr_req_o` stays high with `wr_addr_o`/`wr_data_o` stable until `wr_ack_i` is sampled high. In the cycle after that acknowledge, `wr_req_o` is low.
- R7: A high `wr_ack_i` while `wr_req_o` is low has no effect on the write sequence.
- R8: `done_o` rises only in the cycle after the last write is acknowledged. `busy_o` is high from reset until then, and it is low while `done_o` is high.
- R9: A `start_i` pulse at any point restarts the whole sequence from the power-on delay. In the next cycle `done_o` is low and `adc_rst_no` is high.
- R10: With N_EXTRA = 0 exactly three writes are issued: the correction enable, the accumulator-clear set and the accumulator-clear release.
- R11: While `rst_ni` is low: `adc_rst_no`=1, `wr_req_o`=0, `busy_o`=1, `done_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Synchronous restart of the whole sequence |
| analog_ready_i | input | 1 | High when sampling clock and input signal are present |
| wr_ack_i | input | 1 | Acknowledge from the serial-write engine |
| adc_rst_no | output | 1 | Active-low hardware reset to the converter |
| wr_req_o | output | 1 | Register write request |
| wr_addr_o | output | 8 | Register address of the pending write |
| wr_data_o | output | 16 | Data word of the pending write |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Final write acknowledged |

## Verification
The hardest case to reach is an acknowledge that arrives while no request is pending. It is hard because a well-behaved write engine never produces one. The bench ORs an injected pulse onto the acknowledge line at two points: during the power-on wait, and while the sequencer is held waiting for `analog_ready_i`. It then checks that the full write list still arrives intact and in order. A second instance with an empty extra table runs on the same clock and reset with its ready input held low. This shows that the ready indication, and nothing else, gates its writes.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_PWR   = 3'd0,
    ST_RST   = 3'd1,
    ST_GAP   = 3'd2,
    ST_RDY   = 3'd3,
    ST_WR    = 3'd4,
    ST_SPACE = 3'd5,
    ST_DONE  = 3'd6
  } seq_state_e;

  localparam logic [7:0] REG_CORR_CTRL = 8'h01;
  localparam logic [7:0] REG_ACC_CTRL  = 8'h03;
  localparam int         CORR_EN_BIT   = 15;
  localparam int         ACC_CLR_BIT   = 14;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/seq_delay_timer.sv
module seq_delay_timer #(
  parameter int CNT_W = 8,
  parameter int INIT  = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? load_val_i : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= CNT_W'(INIT);
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);

  a_r1_timer_steps_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/seq_step_rom.sv
module seq_step_rom
  import adc_seq_pkg::*;
#(
  parameter int                   N_EXTRA    = 2,
  parameter int                   IDX_W      = 3,
  parameter logic [((N_EXTRA > 0) ? N_EXTRA : 1)*8-1:0]  EXTRA_ADDR = '0,
  parameter logic [((N_EXTRA > 0) ? N_EXTRA : 1)*16-1:0] EXTRA_DATA = '0,
  parameter logic [15:0]          CORR_BASE  = 16'h0000,
  parameter logic [15:0]          ACC_BASE   = 16'h0000
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [7:0]       addr_o,
  output logic [15:0]      data_o,
  output logic             last_o
);

  localparam logic [15:0] CORR_EN_MASK = 16'(1) << CORR_EN_BIT;
  localparam logic [15:0] ACC_CLR_MASK = 16'(1) << ACC_CLR_BIT;
  localparam logic [IDX_W-1:0] IDX_SET  = IDX_W'(N_EXTRA + 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N_EXTRA + 2);

  always_comb begin
    addr_o = REG_CORR_CTRL;
    data_o = CORR_BASE | CORR_EN_MASK;
    if (idx_i == IDX_SET) begin
      addr_o = REG_ACC_CTRL;
      data_o = ACC_BASE | ACC_CLR_MASK;
    end else if (idx_i == IDX_LAST) begin
      addr_o = REG_ACC_CTRL;
      data_o = ACC_BASE & ~ACC_CLR_MASK;
    end
    for (int k = 0; k < N_EXTRA; k++) begin
      if (idx_i == IDX_W'(k + 1)) begin
        addr_o = EXTRA_ADDR[k*8 +: 8];
        data_o = EXTRA_DATA[k*16 +: 16];
      end
    end
  end

  assign last_o = (idx_i == IDX_LAST);

endmodule

// File: rtl/adc_bringup_seq.sv
module adc_bringup_seq
  import adc_seq_pkg::*;
#(
  parameter int          CLK_MHZ   = 125,
  parameter int          PWRUP_US  = 3000,
  parameter int          RST_NS    = 20,
  parameter int          GAP_NS    = 100,
  parameter int          N_EXTRA   = 2,
  parameter logic [((N_EXTRA > 0) ? N_EXTRA : 1)*8-1:0]  EXTRA_ADDR = '0,
  parameter logic [((N_EXTRA > 0) ? N_EXTRA : 1)*16-1:0] EXTRA_DATA = '0,
  parameter logic [15:0] CORR_BASE = 16'h0000,
  parameter logic [15:0] ACC_BASE  = 16'h0000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        analog_ready_i,
  input  logic        wr_ack_i,
  output logic        adc_rst_no,
  output logic        wr_req_o,
  output logic [7:0]  wr_addr_o,
  output logic [15:0] wr_data_o,
  output logic        busy_o,
  output logic        done_o
);

  localparam int PWR_CYC_RAW = PWRUP_US * CLK_MHZ;
  localparam int PWR_CYC     = (PWR_CYC_RAW > 0) ? PWR_CYC_RAW : 1;
  localparam int RST_CYC     = (RST_NS * CLK_MHZ) / 1000 + 1;
  localparam int GAP_CYC_RAW = ceil_div(GAP_NS * CLK_MHZ, 1000);
  localparam int GAP_CYC     = (GAP_CYC_RAW > 0) ? GAP_CYC_RAW : 1;
  localparam int CNT_W       = $clog2(max3(PWR_CYC, RST_CYC, GAP_CYC) + 1);
  localparam int N_STEPS     = N_EXTRA + 3;
  localparam int IDX_W       = $clog2(N_STEPS);

  // reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  seq_state_e       st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;
  logic             step_last;

  seq_delay_timer #(
    .CNT_W (CNT_W),
    .INIT  (PWR_CYC - 1)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (tmr_expired)
  );

  seq_step_rom #(
    .N_EXTRA    (N_EXTRA),
    .IDX_W      (IDX_W),
    .EXTRA_ADDR (EXTRA_ADDR),
    .EXTRA_DATA (EXTRA_DATA),
    .CORR_BASE  (CORR_BASE),
    .ACC_BASE   (ACC_BASE)
  ) u_rom (
    .idx_i  (idx_q),
    .addr_o (wr_addr_o),
    .data_o (wr_data_o),
    .last_o (step_last)
  );

  // next-state logic
  always_comb begin
    st_d     = st_q;
    idx_d    = idx_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (start_i) begin
      st_d     = ST_PWR;
      idx_d    = '0;
      tmr_load = 1'b1;
      tmr_val  = CNT_W'(PWR_CYC - 1);
    end else begin
      unique case (st_q)
        ST_PWR: if (tmr_expired) begin
          st_d     = ST_RST;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(RST_CYC - 1);
        end
        ST_RST: if (tmr_expired) begin
          st_d     = ST_GAP;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(GAP_CYC - 1);
        end
        ST_GAP:   if (tmr_expired) st_d = ST_RDY;
        ST_RDY:   if (analog_ready_i) st_d = ST_WR;
        ST_WR: if (wr_ack_i) begin
          if (step_last) begin
            st_d = ST_DONE;
          end else begin
            st_d  = ST_SPACE;
            idx_d = idx_q + 1'b1;
          end
        end
        ST_SPACE: st_d = ST_WR;
        ST_DONE:  st_d = ST_DONE;
        default:  st_d = ST_PWR;
      endcase
    end
    idx_en = (idx_d != idx_q);
  end

  // state registers
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) st_q <= ST_PWR;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  assign adc_rst_no = (st_q != ST_RST);
  assign wr_req_o   = (st_q == ST_WR);
  assign done_o     = (st_q == ST_DONE);
  assign busy_o     = (st_q != ST_DONE);

  a_r6_hold_request: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_req_o && !wr_ack_i && !start_i) |=>
      (wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o)));

  a_r6_drop_after_ack: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_req_o && wr_ack_i) |=> !wr_req_o);

  a_r4_hold_for_ready: assert property (@(posedge clk_i) disable iff (!rst_n)
    (st_q == ST_RDY && !analog_ready_i && !start_i) |=> !wr_req_o);

  a_r8_done_after_last_ack: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(done_o) |-> $past(wr_ack_i && wr_req_o && step_last));

  a_r9_restart: assert property (@(posedge clk_i) disable iff (!rst_n)
    start_i |=> (adc_rst_no && !done_o && !wr_req_o));

  a_r3_first_write_index: assert property (@(posedge clk_i) disable iff (!rst_n)
    (st_q == ST_RDY) |-> (idx_q == '0));

endmodule

// File: tb/adc_bringup_seq_tb_top.sv
module tb_wr_sink (
  input  logic        clk,
  input  logic        req,
  input  logic [7:0]  addr,
  input  logic [15:0] data,
  input  int          lat,
  input  logic        clr,
  output logic        ack
);
  logic [23:0] log_q [16];
  int          n_log;
  int          hold_viol;
  int          gap_viol;
  int          wcnt;
  logic        p_req, p_ack;
  logic [23:0] p_word;

  initial begin
    ack = 1'b0; n_log = 0; hold_viol = 0; gap_viol = 0; wcnt = 0;
    p_req = 1'b0; p_ack = 1'b0; p_word = '0;
  end

  always @(negedge clk) begin
    if (clr) begin
      n_log = 0; hold_viol = 0; gap_viol = 0; wcnt = 0;
    end
    if (p_req && !p_ack && req && ({addr, data} != p_word)) hold_viol++;
    if (p_req && p_ack && req) gap_viol++;
    p_req  = req;
    p_ack  = ack;
    p_word = {addr, data};
    ack    = 1'b0;
    if (req && !p_ack) begin
      if (wcnt >= lat) begin
        ack = 1'b1;
        if (n_log < 16) log_q[n_log] = {addr, data};
        n_log++;
        wcnt = 0;
      end else begin
        wcnt++;
      end
    end
  end
endmodule

module adc_bringup_seq_tb_top;
  localparam int PWR_US = 20;
  localparam int P_CYC  = PWR_US * 125;
  localparam int PER    = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_ni, start, rdy_a, rdy_b, spur, clr;
  int   lat_a, lat_b;
  logic ack_a_s, ack_b_s, ack_a, ack_b;
  logic rstn_a, req_a, busy_a, done_a;
  logic rstn_b, req_b, busy_b, done_b;
  logic [7:0]  addr_a, addr_b;
  logic [15:0] data_a, data_b;

  assign ack_a = ack_a_s | spur;
  assign ack_b = ack_b_s;

  adc_bringup_seq #(
    .CLK_MHZ(125), .PWRUP_US(PWR_US), .RST_NS(20), .GAP_NS(100), .N_EXTRA(2),
    .EXTRA_ADDR({8'h2B, 8'h0A}), .EXTRA_DATA({16'hBEEF, 16'h1234}),
    .CORR_BASE(16'h0012), .ACC_BASE(16'h4005)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .analog_ready_i(rdy_a),
    .wr_ack_i(ack_a), .adc_rst_no(rstn_a), .wr_req_o(req_a), .wr_addr_o(addr_a),
    .wr_data_o(data_a), .busy_o(busy_a), .done_o(done_a));

  adc_bringup_seq #(
    .CLK_MHZ(125), .PWRUP_US(PWR_US), .RST_NS(20), .GAP_NS(100), .N_EXTRA(0),
    .CORR_BASE(16'h0000), .ACC_BASE(16'h0000)
  ) dut_empty_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(1'b0), .analog_ready_i(rdy_b),
    .wr_ack_i(ack_b), .adc_rst_no(rstn_b), .wr_req_o(req_b), .wr_addr_o(addr_b),
    .wr_data_o(data_b), .busy_o(busy_b), .done_o(done_b));

  tb_wr_sink sink_a (.clk(clk), .req(req_a), .addr(addr_a), .data(data_a),
                     .lat(lat_a), .clr(clr), .ack(ack_a_s));
  tb_wr_sink sink_b (.clk(clk), .req(req_b), .addr(addr_b), .data(data_b),
                     .lat(lat_b), .clr(clr), .ack(ack_b_s));

  int  n_chk = 0, n_fail = 0;
  bit  finished = 0;
  time t_ref, t_fall, t_rise, t_req;
  bit  seen_req;

  always @(negedge rstn_a) t_fall = $time;
  always @(posedge rstn_a) t_rise = $time;
  always @(posedge req_a) if (!seen_req) begin t_req = $time; seen_req = 1; end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  task automatic wait_done_a(input int max_cyc);
    for (int i = 0; i < max_cyc; i++) begin
      @(negedge clk);
      if (done_a) return;
    end
  endtask

  task automatic check_log_a(input string tag);
    logic [23:0] exp_q [5];
    exp_q[0] = {8'h01, 16'h8012};
    exp_q[1] = {8'h0A, 16'h1234};
    exp_q[2] = {8'h2B, 16'hBEEF};
    exp_q[3] = {8'h03, 16'h4005};
    exp_q[4] = {8'h03, 16'h0005};
    chk(sink_a.n_log == 5, {tag, " write count"}, sink_a.n_log, 5);
    for (int k = 0; k < 5; k++)
      chk(sink_a.log_q[k] == exp_q[k], {tag, " write order"}, sink_a.log_q[k], exp_q[k]);
  endtask

  // R11: outputs while reset is held
  task automatic t_reset_state();
    @(negedge clk);
    chk(rstn_a == 1'b1, "R11 reset pin high", rstn_a, 1);
    chk(req_a == 1'b0, "R11 no request", req_a, 0);
    chk(busy_a == 1'b1 && done_a == 1'b0, "R11 busy/done", {busy_a, done_a}, 2);
  endtask

  // R1 R2 R3 R5 R8 from reset release; R4 on the empty-table instance
  task automatic t_power_up();
    seen_req = 0;
    @(negedge clk);
    rst_ni = 1'b1;
    t_ref = $time;
    wait_done_a(P_CYC + 400);
    chk(done_a == 1'b1 && busy_a == 1'b0, "R8 done after sequence", {busy_a, done_a}, 1);
    chk((t_fall - t_ref) >= P_CYC*PER && (t_fall - t_ref) <= (P_CYC+3)*PER,
        "R1 power-on delay", t_fall - t_ref, P_CYC*PER);
    chk((t_rise - t_fall) == 24 && (t_rise - t_fall) > 20, "R2 reset pulse width",
        t_rise - t_fall, 24);
    chk(seen_req && (t_req - t_rise) >= 100 && (t_req - t_rise) <= 120,
        "R3 settle gap", t_req - t_rise, 112);
    check_log_a("R5");
    chk(sink_a.hold_viol == 0 && sink_a.gap_viol == 0, "R6 handshake",
        sink_a.hold_viol + sink_a.gap_viol, 0);
    chk(sink_b.n_log == 0 && req_b == 1'b0 && busy_b == 1'b1, "R4 waits for ready",
        sink_b.n_log, 0);
  endtask

  // R10: empty table releases after ready
  task automatic t_empty_table();
    @(negedge clk);
    rdy_b = 1'b1;
    for (int i = 0; i < 200 && !done_b; i++) @(negedge clk);
    chk(done_b == 1'b1, "R10 empty table done", done_b, 1);
    chk(sink_b.n_log == 3, "R10 write count", sink_b.n_log, 3);
    chk(sink_b.log_q[0] == 24'h01_8000, "R10 enable write", sink_b.log_q[0], 24'h01_8000);
    chk(sink_b.log_q[1] == 24'h03_4000, "R10 clear set", sink_b.log_q[1], 24'h03_4000);
    chk(sink_b.log_q[2] == 24'h03_0000, "R10 clear release", sink_b.log_q[2], 24'h03_0000);
  endtask

  // R9 restart and R7 stray acknowledges
  task automatic t_restart_spurious();
    @(negedge clk);
    rdy_a = 1'b0;
    clr = 1'b1;
    start = 1'b1;
    t_ref = $time + 4;
    @(negedge clk);
    clr = 1'b0;
    start = 1'b0;
    chk(done_a == 1'b0 && rstn_a == 1'b1, "R9 restart clears done", done_a, 0);
    repeat (50) @(negedge clk);
    spur = 1'b1;
    repeat (3) @(negedge clk);
    spur = 1'b0;
    for (int i = 0; i < P_CYC + 100 && !(rstn_a && t_rise > t_ref); i++) @(negedge clk);
    chk((t_fall - t_ref) >= P_CYC*PER && (t_fall - t_ref) <= (P_CYC+2)*PER,
        "R9 restart power-on delay", t_fall - t_ref, P_CYC*PER);
    repeat (40) @(negedge clk);
    chk(req_a == 1'b0 && sink_a.n_log == 0, "R4 held without ready", sink_a.n_log, 0);
    spur = 1'b1;
    repeat (2) @(negedge clk);
    spur = 1'b0;
    rdy_a = 1'b1;
    wait_done_a(200);
    check_log_a("R7");
  endtask

  // R6: slow write engine
  task automatic t_slow_engine();
    @(negedge clk);
    lat_a = 5;
    clr = 1'b1;
    start = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    start = 1'b0;
    wait_done_a(P_CYC + 500);
    chk(done_a == 1'b1, "R8 done with slow engine", done_a, 1);
    chk(sink_a.hold_viol == 0, "R6 request held stable", sink_a.hold_viol, 0);
    chk(sink_a.gap_viol == 0, "R6 request drops after ack", sink_a.gap_viol, 0);
    check_log_a("R6");
  endtask

  initial begin
    rst_ni = 1'b0; start = 1'b0; rdy_a = 1'b1; rdy_b = 1'b0; spur = 1'b0;
    clr = 1'b0; lat_a = 1; lat_b = 0; seen_req = 0;
    t_ref = 0; t_fall = 0; t_rise = 0; t_req = 0;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_power_up();
    t_empty_table();
    t_restart_spurious();
    t_slow_engine();
    finish_run();
  end
endmodule